// File: doc/BRIEF.md
# Filtered Pin Change Interrupt Unit

This block watches the raw levels of a bank of input pads and turns level changes into an interrupt. Each pad first crosses into the clock domain through a synchroniser. It can then pass through a glitch filter, chosen per pin, that takes samples on both clock edges and accepts a new level only when two half-cycle samples in a row agree. The qualified level of every pin is offered on `pin_data_o`.

Any change of the qualified level, rising or falling, sets that pin's bit in a change status register. The status register is set whether or not the pin is enabled for interrupts, and it does not depend on who drives the pad or in which direction. A status read returns the register and clears it in the same cycle. A change that arrives in that same cycle is kept for the next read. The single interrupt line is high while any status bit is set whose pin is enabled in the interrupt mask. Software changes the interrupt mask and the filter selection through write-only set and clear commands. Both registers can be read back at the ports.

Top module: `pin_change_irq`

## Requirements
- R1: After reset, the interrupt mask, the filter selection and the change status are all zero, and `irq_o` is low.
- R2: A write with `cfg_sel`=0 sets the interrupt mask bits that are 1 in `cfg_wdata`. A write with `cfg_sel`=1 clears them. A mask bit of 1 means enabled, and bits that are 0 in `cfg_wdata` keep their value.
- R3: A write with `cfg_sel`=2 turns the glitch filter on for the pins that are 1 in `cfg_wdata`. A write with `cfg_sel`=3 turns it off for them. Other pins keep their setting.
- R4: For an unfiltered pin, a pad level sampled by rising edge k appears on `pin_data_o` after rising edge k+2. A pulse that covers only one rising edge still produces two changes.
- R5: For a filtered pin, a pad pulse shorter than half a clock period that covers a single clock edge leaves `pin_data_o` and the status bit unchanged.
- R6: For a filtered pin, a pad level that holds from before rising edge k until after the following falling edge is accepted, and it appears on `pin_data_o` after rising edge k+2.
- R7: Every rising or falling change of a pin's qualified level sets that pin's status bit, whatever the mask. A set bit stays set until it is read.
- R8: `stat_rdata` always shows the status register. A cycle with `stat_rd` high clears it at the next rising edge.
- R9: A change that reaches the status register in a cycle with `stat_rd` high is held in the status after that edge.
- R10: `irq_o` is high exactly when some status bit is set whose interrupt mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the filter also samples on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pad_i | input | N_PINS | Raw, asynchronous pad levels |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Command: 0 mask set, 1 mask clear, 2 filter on, 3 filter off |
| cfg_wdata | input | N_PINS | Pin select for the command |
| stat_rd | input | 1 | Status read strobe; clears the status at the next edge |
| stat_rdata | output | N_PINS | Change status register |
| irq_mask_o | output | N_PINS | Interrupt mask readback (1 = enabled) |
| filt_mask_o | output | N_PINS | Filter selection readback (1 = filtered) |
| pin_data_o | output | N_PINS | Synchronised and qualified pin levels |
| irq_o | output | 1 | Combined change interrupt |

## Verification
The two functions that can fall in the same cycle are the clear done by a status read and the setting of a status bit by a fresh pin change. The bench holds `stat_rd` high across several cycles while it drives a pad edge, so the change lands on a clearing edge. It then expects that pin's bit to be visible for one cycle and gone after the next read edge. A long randomised phase mixes reads, mask and filter commands and pad toggles at uneven offsets, including pulses that straddle one edge. A behavioural model built from queues of edge samples judges every cycle.

// File: rtl/pci_pkg.sv
package pci_pkg;
   typedef enum logic [1:0] {
      CMD_IRQ_ON  = 2'd0,
      CMD_IRQ_OFF = 2'd1,
      CMD_FLT_ON  = 2'd2,
      CMD_FLT_OFF = 2'd3
   } cfg_cmd_e;
endpackage

// File: rtl/pci_setclr.sv
module pci_setclr #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);
   logic [N-1:0] q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= '0;
      else        q_r <= (q_r | set_i) & ~clr_i;
   end

   assign q_o = q_r;

   // R2 / R3: a set command leaves its bits at one, a clear command at zero
   a_r2_r3_set: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_i != '0) && (clr_i == '0)) |=> ((q_r & $past(set_i)) == $past(set_i)));
   a_r2_r3_clr: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_i != '0) && (set_i == '0)) |=> ((q_r & $past(clr_i)) == '0));
   a_r2_r3_keep: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_i == '0) && (clr_i == '0)) |=> $stable(q_r));
endmodule

// File: rtl/pci_sync.sv
module pci_sync #(
   parameter int N      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d_i,
   output logic [N-1:0] rise_o,
   output logic [N-1:0] fall_o
);
   logic [N-1:0] rchain [STAGES];
   logic [N-1:0] fchain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("pci_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) rchain[s] <= '0;
      end else begin
         rchain[0] <= d_i;
         for (int s = 1; s < STAGES; s++) rchain[s] <= rchain[s-1];
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) fchain[s] <= '0;
      end else begin
         fchain[0] <= d_i;
         for (int s = 1; s < STAGES; s++) fchain[s] <= fchain[s-1];
      end
   end

   assign rise_o = rchain[STAGES-1];
   assign fall_o = fchain[STAGES-1];
endmodule

// File: rtl/pci_filter.sv
module pci_filter #(
   parameter int N         = 32,
   parameter bit FILTER_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] rise_i,
   input  logic [N-1:0] fall_i,
   input  logic [N-1:0] flt_en_i,
   output logic [N-1:0] lvl_o,
   output logic [N-1:0] chg_o
);
   logic [N-1:0] lvl_r;
   logic [N-1:0] lvl_nxt;
   logic [N-1:0] take;

   generate
      if (FILTER_EN) begin : g_filter
         // a pin moves when unfiltered, or when both half-cycle samples agree
         assign take = ~flt_en_i | ~(rise_i ^ fall_i);
      end else begin : g_bypass
         assign take = '1;
      end
   endgenerate

   always_comb begin
      lvl_nxt = (rise_i & take) | (lvl_r & ~take);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_r <= '0;
      else        lvl_r <= lvl_nxt;
   end

   assign lvl_o = lvl_r;
   assign chg_o = lvl_nxt ^ lvl_r;

   // R5: a filtered pin whose two half-cycle samples differ holds its level
   a_r5_hold_on_disagree: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((lvl_r ^ $past(lvl_r)) & $past(flt_en_i & (rise_i ^ fall_i))) == '0));
   // R4 / R6: an accepted sample is what the pin shows after the edge
   a_r6_follow_accepted: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((lvl_r & $past(take)) == ($past(rise_i) & $past(take))));
endmodule

// File: rtl/pci_status.sv
module pci_status #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] chg_i,
   input  logic         rd_i,
   input  logic [N-1:0] mask_i,
   output logic [N-1:0] stat_o,
   output logic         irq_o
);
   logic [N-1:0] stat_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    stat_r <= '0;
      else if (rd_i) stat_r <= chg_i;
      else           stat_r <= stat_r | chg_i;
   end

   assign stat_o = stat_r;
   assign irq_o  = |(stat_r & mask_i);

   // R7: bits stay set while nobody reads
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> ((stat_r & $past(stat_r)) == $past(stat_r)));
   // R8: a read clears everything except fresh changes
   a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i |=> ((stat_r & ~$past(chg_i)) == '0));
   // R9: a change arriving with a read is still recorded
   a_r9_keep_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_i != '0) |=> ((stat_r & $past(chg_i)) == $past(chg_i)));
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
   parameter int N_PINS      = 32,
   parameter int SYNC_STAGES = 2,
   parameter bit FILTER_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] pad_i,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [N_PINS-1:0] cfg_wdata,
   input  logic              stat_rd,
   output logic [N_PINS-1:0] stat_rdata,
   output logic [N_PINS-1:0] irq_mask_o,
   output logic [N_PINS-1:0] filt_mask_o,
   output logic [N_PINS-1:0] pin_data_o,
   output logic              irq_o
);
   import pci_pkg::*;

   localparam int W = N_PINS;

   generate
      if (W < 1) begin : g_bad_width
         $error("pin_change_irq: N_PINS must be positive");
      end
   endgenerate

   cfg_cmd_e     cmd;
   logic [W-1:0] irq_set, irq_clr, flt_set, flt_clr;
   logic [W-1:0] mask_q, flt_q;
   logic [W-1:0] s_rise, s_fall, lvl, chg;

   assign cmd = cfg_cmd_e'(cfg_sel);

   always_comb begin
      irq_set = '0;
      irq_clr = '0;
      flt_set = '0;
      flt_clr = '0;
      if (cfg_we) begin
         unique case (cmd)
            CMD_IRQ_ON:  irq_set = cfg_wdata;
            CMD_IRQ_OFF: irq_clr = cfg_wdata;
            CMD_FLT_ON:  flt_set = cfg_wdata;
            CMD_FLT_OFF: flt_clr = cfg_wdata;
            default: ;
         endcase
      end
   end

   pci_setclr #(.N(W)) u_mask (
      .clk(clk), .rst_n(rst_n), .set_i(irq_set), .clr_i(irq_clr), .q_o(mask_q));

   pci_setclr #(.N(W)) u_fsel (
      .clk(clk), .rst_n(rst_n), .set_i(flt_set), .clr_i(flt_clr), .q_o(flt_q));

   pci_sync #(.N(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pad_i), .rise_o(s_rise), .fall_o(s_fall));

   pci_filter #(.N(W), .FILTER_EN(FILTER_EN)) u_filt (
      .clk(clk), .rst_n(rst_n), .rise_i(s_rise), .fall_i(s_fall),
      .flt_en_i(flt_q), .lvl_o(lvl), .chg_o(chg));

   pci_status #(.N(W)) u_stat (
      .clk(clk), .rst_n(rst_n), .chg_i(chg), .rd_i(stat_rd),
      .mask_i(mask_q), .stat_o(stat_rdata), .irq_o(irq_o));

   assign irq_mask_o  = mask_q;
   assign filt_mask_o = flt_q;
   assign pin_data_o  = lvl;

   // R10: the line drops once nothing enabled is pending
   a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !cfg_we && (chg == '0)) |=> !irq_o);
   // R1: outputs at their cleared values in reset
   always_comb begin
      if (!rst_n) begin
         a_r1_reset_clear: assert ((stat_rdata == '0) && (mask_q == '0) && (flt_q == '0));
      end
   end
endmodule

// File: tb/pin_change_irq_tb.sv
module pin_change_irq_tb_top;
   localparam int N = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] pad = '0;
   logic         cfg_we = 1'b0;
   logic [1:0]   cfg_sel = 2'd0;
   logic [N-1:0] cfg_wdata = '0;
   logic         stat_rd = 1'b0;
   logic [N-1:0] stat_rdata, irq_mask_o, filt_mask_o, pin_data_o;
   logic         irq_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pin_change_irq #(.N_PINS(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .pad_i(pad), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .stat_rd(stat_rd), .stat_rdata(stat_rdata),
      .irq_mask_o(irq_mask_o), .filt_mask_o(filt_mask_o),
      .pin_data_o(pin_data_o), .irq_o(irq_o));

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: got %h expected %h", req, $time, act, exp);
      end
   endtask

   // ---------------- behavioural reference ----------------
   logic [N-1:0] m_lvl = '0, m_stat = '0, m_imask = '0, m_fmask = '0;
   logic [N-1:0] hi_q[$];
   logic [N-1:0] lo_q[$];

   initial begin
      hi_q = '{'0, '0};
      lo_q = '{'0, '0};
   end

   always @(negedge clk) begin
      if (rst_n) begin
         lo_q.push_back(pad);
         if (lo_q.size() > 3) void'(lo_q.pop_front());
      end
   end

   always @(posedge clk) begin
      logic [N-1:0] hs, ls, nl;
      if (!rst_n) begin
         m_lvl = '0; m_stat = '0; m_imask = '0; m_fmask = '0;
         hi_q = '{'0, '0};
         lo_q = '{'0, '0};
      end else begin
         hs = hi_q[hi_q.size()-2];
         ls = lo_q[lo_q.size()-2];
         nl = m_lvl;
         for (int i = 0; i < N; i++)
            if (!m_fmask[i] || (hs[i] == ls[i])) nl[i] = hs[i];
         m_stat = (stat_rd ? '0 : m_stat) | (nl ^ m_lvl);
         m_lvl = nl;
         if (cfg_we) begin
            case (cfg_sel)
               2'd0: m_imask = m_imask | cfg_wdata;
               2'd1: m_imask = m_imask & ~cfg_wdata;
               2'd2: m_fmask = m_fmask | cfg_wdata;
               default: m_fmask = m_fmask & ~cfg_wdata;
            endcase
         end
         hi_q.push_back(pad);
         if (hi_q.size() > 3) void'(hi_q.pop_front());
      end
      #4;
      if (!done) begin
         chk("R4/R5/R6 pin_data_o", pin_data_o, m_lvl);
         chk("R7/R8/R9 stat_rdata", stat_rdata, m_stat);
         chk("R10 irq_o", {{(N-1){1'b0}}, irq_o}, {{(N-1){1'b0}}, |(m_stat & m_imask)});
         chk("R2 irq_mask_o", irq_mask_o, m_imask);
         chk("R3 filt_mask_o", filt_mask_o, m_fmask);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic cfg(input logic [1:0] sel, input logic [N-1:0] d);
      @(posedge clk); #2;
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(posedge clk); #2;
      cfg_we = 1'b0; cfg_wdata = '0;
   endtask

   task automatic rd_status();
      @(posedge clk); #2;
      stat_rd = 1'b1;
      @(posedge clk); #2;
      stat_rd = 1'b0;
   endtask

   task automatic wait_edges(input int n);
      for (int k = 0; k < n; k++) @(posedge clk);
      #4;
   endtask

   task automatic short_pulse(input logic [N-1:0] pins);
      @(posedge clk); #9;
      pad = pad | pins;
      #3;
      pad = pad & ~pins;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired: got running expected finished");
      finish_run();
   end

   initial begin
      #9;
      // R1: cleared state while reset is held
      chk("R1 irq_mask_o", irq_mask_o, '0);
      chk("R1 filt_mask_o", filt_mask_o, '0);
      chk("R1 stat_rdata", stat_rdata, '0);
      chk("R1 irq_o", {{(N-1){1'b0}}, irq_o}, '0);
      #14 rst_n = 1'b1;

      // R2 / R3 commands
      cfg(2'd0, 32'h0000_00FF);
      cfg(2'd2, 32'h0000_FF00);
      chk("R2 mask set", irq_mask_o, 32'h0000_00FF);
      chk("R3 filter on", filt_mask_o, 32'h0000_FF00);
      cfg(2'd1, 32'h0000_0080);
      chk("R2 mask clear", irq_mask_o, 32'h0000_007F);

      // R4 unfiltered rising change, R7 status, R10 interrupt
      @(posedge clk); #2 pad[0] = 1'b1;
      wait_edges(3);
      chk("R4 pin0 level", {31'd0, pin_data_o[0]}, 32'd1);
      chk("R7 pin0 rise", {31'd0, stat_rdata[0]}, 32'd1);
      chk("R10 irq on masked pin", {31'd0, irq_o}, 32'd1);
      rd_status();
      chk("R8 cleared by read", stat_rdata, '0);
      chk("R10 irq after read", {31'd0, irq_o}, 32'd0);

      // R7 unmasked pin sets status, R10 no interrupt
      @(posedge clk); #2 pad[20] = 1'b1;
      wait_edges(4);
      chk("R7 unmasked pin", stat_rdata, 32'h0010_0000);
      chk("R10 unmasked pin quiet", {31'd0, irq_o}, 32'd0);
      rd_status();

      // R7 falling change
      @(posedge clk); #2 pad[0] = 1'b0;
      wait_edges(4);
      chk("R7 pin0 fall", stat_rdata, 32'h0000_0001);
      rd_status();

      // R5 filtered pulse rejected, R4 unfiltered pulse passed
      short_pulse(32'h0000_0102);
      wait_edges(5);
      chk("R5 filtered pulse level", {31'd0, pin_data_o[8]}, 32'd0);
      chk("R5 filtered pulse status", {31'd0, stat_rdata[8]}, 32'd0);
      chk("R4 unfiltered pulse status", {31'd0, stat_rdata[1]}, 32'd1);
      rd_status();

      // R6 filtered long level
      @(posedge clk); #2 pad[9] = 1'b1;
      wait_edges(3);
      chk("R6 filtered level", {31'd0, pin_data_o[9]}, 32'd1);
      chk("R6 filtered status", {31'd0, stat_rdata[9]}, 32'd1);
      rd_status();

      // R9 change landing on a read edge
      @(posedge clk); #2;
      stat_rd = 1'b1;
      pad[2] = 1'b1;
      wait_edges(3);
      chk("R9 kept during read", stat_rdata, 32'h0000_0004);
      wait_edges(1);
      chk("R8 cleared on next read edge", stat_rdata, '0);
      stat_rd = 1'b0;

      // R3 filter off lets the short pulse through
      cfg(2'd3, 32'h0000_0100);
      chk("R3 filter off", filt_mask_o, 32'h0000_FE00);
      short_pulse(32'h0000_0100);
      wait_edges(5);
      chk("R3 pulse passes unfiltered", {31'd0, stat_rdata[8]}, 32'd1);
      rd_status();

      // randomised soak against the reference model
      for (int it = 0; it < 3000; it++) begin
         @(posedge clk);
         #(1 + $urandom % 3);
         stat_rd = ($urandom % 4 == 0);
         cfg_we = ($urandom % 8 == 0);
         cfg_sel = 2'($urandom);
         cfg_wdata = $urandom;
         if ($urandom % 2 == 0) pad = pad ^ (32'd1 << ($urandom % N));
         if ($urandom % 4 == 0) begin
            #5;
            pad = pad ^ (32'd1 << ($urandom % N));
         end
      end
      @(posedge clk); #2;
      stat_rd = 1'b0; cfg_we = 1'b0;
      wait_edges(4);
      finish_run();
   end
endmodule